// File: doc/BRIEF.md
# Serial Display Link Bring-Up Sequencer

This block powers up a serial display link and the PLL that feeds it, in a fixed order, with no software polling. A one-cycle start pulse makes it hold the pixel clock in free-run, put the PLL into system reset, and then issue a PLL go request. It then waits on three status inputs in turn. First the lock request must stop pending (the input falls). Next the PLL must report lock (the input rises). Last the link must report that its reset is done (the input rises). Between the second and third wait it raises the LCD enable.

Each wait has its own timeout, built from a prescaled millisecond counter. If a wait runs out, the block clears the go request and backs out of its outputs one per cycle. It then pulses a failure flag and keeps a 2-bit code that names the stage that failed. On success it pulses a done flag and leaves the link up. A separate stop command takes a running link down in its own order.

Top module: `link_bringup_seq`

## Requirements
- R1: While reset is applied and after it, all outputs are 0 and `fail_stage_o` is 0, until a start is accepted.
- R2: A start pulse is accepted only when the block is idle. In the next cycle `pclk_free_o` and `busy_o` are 1 and `fail_stage_o` is cleared to 0. One cycle after that `pll_rst_o` rises.
- R3: `pll_go_o` rises exactly `HOLD_CYC` cycles after `pll_rst_o` rises, and it is only ever high while `pll_rst_o` is high.
- R4: While `pll_go_o` is high, the first clock edge that samples `ack_pend_i` low makes `pll_go_o` fall after that edge. This can happen on the first edge of the wait.
- R5: After the acknowledge, the first edge that samples `pll_lock_i` high raises `lcd_en_o` after that edge.
- R6: After `lcd_en_o` rises, the first edge that samples `link_rdy_i` high gives a one-cycle `done_o` pulse and drops `busy_o`. `pclk_free_o`, `pll_rst_o` and `lcd_en_o` stay 1 and `pll_go_o` stays 0.
- R7: A wait fails only if its condition is false on `CYC_PER_MS*TIMEOUT_MS+1` consecutive edges in that wait. If the condition is met on the last of those edges, the block advances and does not fail.
- R8: On a timeout, after the failing edge `pll_go_o` and `lcd_en_o` are 0 and `fail_stage_o` holds the stage (1 = acknowledge, 2 = lock, 3 = link ready). After the next edge `pll_rst_o` is 0. After the one after that, `pclk_free_o` is 0, `fail_o` pulses for one cycle and `busy_o` falls. The code holds until the next accepted start.
- R9: A stop pulse sampled while not busy (link up or idle) clears `lcd_en_o`. After the next edge `pclk_free_o` is 0, and after the one after that `pll_rst_o` is 0. A stop sampled while busy has no effect.
- R10: A start sampled while busy, while the link is up, or during teardown has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for the bring-up sequence |
| stop_i | input | 1 | Stop pulse that tears the link down |
| ack_pend_i | input | 1 | PLL lock request still pending (wait for 0) |
| pll_lock_i | input | 1 | PLL locked (wait for 1) |
| link_rdy_i | input | 1 | Link reset completed (wait for 1) |
| pclk_free_o | output | 1 | Pixel clock free-run enable |
| pll_rst_o | output | 1 | PLL system reset |
| pll_go_o | output | 1 | PLL go request |
| lcd_en_o | output | 1 | LCD output enable |
| busy_o | output | 1 | High from an accepted start until done or failure |
| done_o | output | 1 | One-cycle pulse on success |
| fail_o | output | 1 | One-cycle pulse at the end of failure unwinding |
| fail_stage_o | output | 2 | Stage that timed out, 0 if none |

## Verification
The hardest case to reach is a wait condition that comes true on exactly the last edge the timeout allows. A single cycle decides between advancing and failing, and status that is simply stuck never tests that edge. The stimulus waits for the go request to appear at the ports and counts the timeout window from that cycle. It then releases the acknowledge either on the final permitted edge or one edge later, and runs both variants. Starts and stops are also fired in the middle of waits and of teardown. A behavioural model checks every clock that they leave no mark.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RSTON, ST_HOLD, ST_ACK, ST_LOCK, ST_RDY, ST_UP,
    ST_F_RST, ST_F_CLK, ST_D_CLK, ST_D_RST
  } seq_state_t;

  typedef enum logic [1:0] {
    STG_NONE = 2'd0, STG_ACK = 2'd1, STG_LOCK = 2'd2, STG_RDY = 2'd3
  } stage_code_t;
endpackage

// File: rtl/lbs_timeout.sv
module lbs_timeout #(
  parameter int CYC_PER_MS = 100000,
  parameter int TIMEOUT_MS = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic expired
);
  localparam int PW = $clog2(CYC_PER_MS + 1);
  localparam int MW = $clog2(TIMEOUT_MS + 1);

  logic [PW-1:0] pre_q;
  logic [MW-1:0] ms_q;

  assign expired = (ms_q == MW'(TIMEOUT_MS));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (!expired) begin
      if (pre_q == PW'(CYC_PER_MS - 1)) begin
        pre_q <= '0;
        ms_q  <= ms_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lbs_hold.sv
module lbs_hold #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic fin
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] cnt_q;

  assign fin = run && (cnt_q == HW'(HOLD_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (!fin)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lbs_fsm.sv
module lbs_fsm
  import lbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       ack_pend_i,
  input  logic       pll_lock_i,
  input  logic       link_rdy_i,
  input  logic       tmo,
  input  logic       hold_fin,
  output logic       tmr_clr,
  output logic       hold_run,
  output logic       pclk_free_o,
  output logic       pll_rst_o,
  output logic       pll_go_o,
  output logic       lcd_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       fail_o,
  output logic [1:0] fail_stage_o
);
  seq_state_t  state_q;
  logic        in_wait, met;
  stage_code_t cur_stage;

  always_comb begin
    in_wait   = 1'b0;
    met       = 1'b0;
    cur_stage = STG_NONE;
    case (state_q)
      ST_ACK:  begin in_wait = 1'b1; met = !ack_pend_i; cur_stage = STG_ACK;  end
      ST_LOCK: begin in_wait = 1'b1; met = pll_lock_i;  cur_stage = STG_LOCK; end
      ST_RDY:  begin in_wait = 1'b1; met = link_rdy_i;  cur_stage = STG_RDY;  end
      default: ;
    endcase
    tmr_clr  = !in_wait || met;
    hold_run = (state_q == ST_HOLD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      pclk_free_o  <= 1'b0;
      pll_rst_o    <= 1'b0;
      pll_go_o     <= 1'b0;
      lcd_en_o     <= 1'b0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      fail_o       <= 1'b0;
      fail_stage_o <= STG_NONE;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      if (in_wait && !met && tmo) begin
        pll_go_o     <= 1'b0;
        lcd_en_o     <= 1'b0;
        fail_stage_o <= cur_stage;
        state_q      <= ST_F_RST;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (start_i) begin
              pclk_free_o  <= 1'b1;
              busy_o       <= 1'b1;
              fail_stage_o <= STG_NONE;
              state_q      <= ST_RSTON;
            end else if (stop_i) begin
              lcd_en_o <= 1'b0;
              state_q  <= ST_D_CLK;
            end
          end
          ST_RSTON: begin
            pll_rst_o <= 1'b1;
            state_q   <= ST_HOLD;
          end
          ST_HOLD: begin
            if (hold_fin) begin
              pll_go_o <= 1'b1;
              state_q  <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (met) begin
              pll_go_o <= 1'b0;
              state_q  <= ST_LOCK;
            end
          end
          ST_LOCK: begin
            if (met) begin
              lcd_en_o <= 1'b1;
              state_q  <= ST_RDY;
            end
          end
          ST_RDY: begin
            if (met) begin
              done_o  <= 1'b1;
              busy_o  <= 1'b0;
              state_q <= ST_UP;
            end
          end
          ST_UP: begin
            if (stop_i) begin
              lcd_en_o <= 1'b0;
              state_q  <= ST_D_CLK;
            end
          end
          ST_F_RST: begin
            pll_rst_o <= 1'b0;
            state_q   <= ST_F_CLK;
          end
          ST_F_CLK: begin
            pclk_free_o <= 1'b0;
            fail_o      <= 1'b1;
            busy_o      <= 1'b0;
            state_q     <= ST_IDLE;
          end
          ST_D_CLK: begin
            pclk_free_o <= 1'b0;
            state_q     <= ST_D_RST;
          end
          ST_D_RST: begin
            pll_rst_o <= 1'b0;
            state_q   <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: the go request is only issued inside the PLL reset window
  assert_go_in_reset_R3: assert property (@(posedge clk) disable iff (rst)
    pll_go_o |-> pll_rst_o);

  // R5: LCD enable only while the clock and PLL reset are held
  assert_lcd_needs_clock_R5: assert property (@(posedge clk) disable iff (rst)
    lcd_en_o |-> (pclk_free_o && pll_rst_o));

  // R6: success leaves the link fully up
  assert_done_link_up_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lcd_en_o && pclk_free_o && pll_rst_o && !pll_go_o && !busy_o));

  // R8: the failure pulse comes after everything is unwound
  assert_fail_unwound_R8: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (!pclk_free_o && !pll_rst_o && !lcd_en_o && !pll_go_o && fail_stage_o != 2'd0));

  // R8: the stage code does not move while the block is idle
  assert_code_held_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o)) |-> $stable(fail_stage_o));

  // R9: PLL reset is only released once the LCD is off
  assert_rst_after_lcd_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_rst_o) |-> !lcd_en_o);

  // R6, R8: done and fail never coincide
  assert_done_fail_excl_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, fail_o}));
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq #(
  parameter int CYC_PER_MS = 100000,
  parameter int TIMEOUT_MS = 500,
  parameter int HOLD_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       ack_pend_i,
  input  logic       pll_lock_i,
  input  logic       link_rdy_i,
  output logic       pclk_free_o,
  output logic       pll_rst_o,
  output logic       pll_go_o,
  output logic       lcd_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       fail_o,
  output logic [1:0] fail_stage_o
);
  logic tmr_clr, tmo, hold_run, hold_fin;

  lbs_timeout #(.CYC_PER_MS(CYC_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)) u_tmo (
    .clk(clk), .rst(rst), .clr(tmr_clr), .expired(tmo)
  );

  lbs_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .run(hold_run), .fin(hold_fin)
  );

  lbs_fsm u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .ack_pend_i(ack_pend_i), .pll_lock_i(pll_lock_i), .link_rdy_i(link_rdy_i),
    .tmo(tmo), .hold_fin(hold_fin), .tmr_clr(tmr_clr), .hold_run(hold_run),
    .pclk_free_o(pclk_free_o), .pll_rst_o(pll_rst_o), .pll_go_o(pll_go_o),
    .lcd_en_o(lcd_en_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .fail_stage_o(fail_stage_o)
  );
endmodule

// File: tb/tb_link_bringup_seq.sv
module tb_link_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CPM  = 4;
  localparam int TMS  = 3;
  localparam int HOLD = 2;
  localparam int NWIN = CPM * TMS;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, stop_i = 0, ack_pend_i = 0, pll_lock_i = 0, link_rdy_i = 0;
  logic pclk_free_o, pll_rst_o, pll_go_o, lcd_en_o, busy_o, done_o, fail_o;
  logic [1:0] fail_stage_o;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_bringup_seq #(.CYC_PER_MS(CPM), .TIMEOUT_MS(TMS), .HOLD_CYC(HOLD)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .ack_pend_i(ack_pend_i), .pll_lock_i(pll_lock_i), .link_rdy_i(link_rdy_i),
    .pclk_free_o(pclk_free_o), .pll_rst_o(pll_rst_o), .pll_go_o(pll_go_o),
    .lcd_en_o(lcd_en_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .fail_stage_o(fail_stage_o)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase numbers walk the written sequence
  int ph = 0, hc = 0, wc = 0;
  bit m_pf, m_sr, m_go, m_lcd, m_busy, m_done, m_fail;
  int m_code = 0;

  task automatic m_timeout(int stage);
    m_go = 0; m_lcd = 0; m_code = stage; ph = 7;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; m_pf = 0; m_sr = 0; m_go = 0; m_lcd = 0;
      m_busy = 0; m_done = 0; m_fail = 0; m_code = 0;
    end else begin
      m_done = 0; m_fail = 0;
      case (ph)
        0: if (start_i) begin m_pf = 1; m_busy = 1; m_code = 0; ph = 1; end
           else if (stop_i) begin m_lcd = 0; ph = 9; end
        1: begin m_sr = 1; hc = 0; ph = 2; end
        2: begin hc++; if (hc == HOLD) begin m_go = 1; wc = 0; ph = 3; end end
        3: if (!ack_pend_i) begin m_go = 0; wc = 0; ph = 4; end
           else if (wc == NWIN) m_timeout(1); else wc++;
        4: if (pll_lock_i) begin m_lcd = 1; wc = 0; ph = 5; end
           else if (wc == NWIN) m_timeout(2); else wc++;
        5: if (link_rdy_i) begin m_done = 1; m_busy = 0; ph = 6; end
           else if (wc == NWIN) m_timeout(3); else wc++;
        6: if (stop_i) begin m_lcd = 0; ph = 9; end
        7: begin m_sr = 0; ph = 8; end
        8: begin m_pf = 0; m_fail = 1; m_busy = 0; ph = 0; end
        9: begin m_pf = 0; ph = 10; end
        10: begin m_sr = 0; ph = 0; end
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2 pclk_free",   pclk_free_o,  m_pf);
      check("R3 pll_rst",     pll_rst_o,    m_sr);
      check("R4 pll_go",      pll_go_o,     m_go);
      check("R5 lcd_en",      lcd_en_o,     m_lcd);
      check("R10 busy",       busy_o,       m_busy);
      check("R6 done",        done_o,       m_done);
      check("R8 fail",        fail_o,       m_fail);
      check("R8 fail_stage",  fail_stage_o, m_code);
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_go();
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (pll_go_o) return;
    end
    check("R3 go never rose", 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 outputs in reset", {pclk_free_o, pll_rst_o, pll_go_o, lcd_en_o, busy_o, done_o, fail_o}, 0);
    rst = 0;
    @(negedge clk);
    check("R1 code after reset", fail_stage_o, 0);

    // Normal bring-up with late status, start and stop fired mid-sequence
    ack_pend_i = 1; pll_lock_i = 0; link_rdy_i = 0;
    pulse_start();
    check("R2 busy after start", busy_o, 1);
    idle(4); pulse_start(); pulse_stop();
    idle(2); ack_pend_i = 0;
    idle(3); pll_lock_i = 1;
    idle(3); link_rdy_i = 1;
    idle(3);
    check("R6 link up lcd", lcd_en_o, 1);
    check("R6 link up busy", busy_o, 0);
    pulse_start(); idle(2);
    check("R10 start while up ignored", {busy_o, pll_go_o}, 0);
    pulse_stop(); pulse_start(); idle(4);
    check("R9 torn down", {pclk_free_o, pll_rst_o, lcd_en_o}, 0);
    check("R10 start in teardown ignored", busy_o, 0);

    // Stage 1 timeout
    ack_pend_i = 1; pll_lock_i = 0; link_rdy_i = 0;
    pulse_start(); idle(NWIN + 12);
    check("R7 stage1 timeout code", fail_stage_o, 1);
    pulse_stop(); idle(5);
    check("R8 code held while idle", fail_stage_o, 1);
    ack_pend_i = 0;
    pulse_start();
    check("R8 code cleared by start", fail_stage_o, 0);
    // immediate ack, lock never comes
    idle(NWIN + 14);
    check("R7 stage2 timeout code", fail_stage_o, 2);

    // Stage 3 timeout
    pll_lock_i = 1;
    pulse_start(); idle(NWIN + 14);
    check("R7 stage3 timeout code", fail_stage_o, 3);
    check("R8 all low after fail", {pclk_free_o, pll_rst_o, pll_go_o, lcd_en_o, busy_o}, 0);

    // Boundary: ack released on the last permitted edge
    ack_pend_i = 1; pll_lock_i = 1; link_rdy_i = 1;
    start_i = 1; @(negedge clk); start_i = 0;
    wait_go();
    idle(NWIN); ack_pend_i = 0;
    idle(5);
    check("R7 last-edge ack advances", fail_stage_o, 0);
    check("R7 last-edge ack link up", lcd_en_o, 1);
    pulse_stop(); idle(4);

    // Boundary: ack one edge too late
    ack_pend_i = 1;
    start_i = 1; @(negedge clk); start_i = 0;
    wait_go();
    idle(NWIN + 1); ack_pend_i = 0;
    idle(5);
    check("R7 late ack fails", fail_stage_o, 1);
    check("R7 late ack no lcd", lcd_en_o, 0);
    idle(3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule